// File: doc/BRIEF.md
# Boot Overlay and Address Decoder

This block is the glue between a CPU with an asynchronous 16-bit bus and its memories and peripherals. The CPU presents a 23-bit word address (byte address bits 23:1), an active-low address strobe, active-low strobes for the upper and lower byte lanes, and a read/write line. The block decodes each bus cycle into one chip select and per-lane output and write enables. It also returns an active-low transfer acknowledge after a set number of wait clocks. All inputs are taken to be synchronous to `clk`, and every output is registered.

The CPU fetches its reset vectors from address zero, while RAM must occupy address zero in normal operation. To handle this, a boot overlay counts completed strobe cycles after reset. For the first four cycles it forces ROM selection whatever the address. After that it lets the address map take over until the next reset.

The map places ROM in a single 64 KB page (0x50 by default, or 0xFF when `ROM_AT_TOP` is set), serial at page 0xFE, video at 0xFD, the microcontroller at 0xFB, and RAM below 0x400000. A cycle to any other address still gets an acknowledge after a timeout, so the bus cannot hang. Such a cycle also sets a sticky flag.

Top module: `boot_decode_glue`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `boot_n` is 0, all chip selects, output enables and write enables are 1, `dtack_n` is 1 and `unmapped` is 0.
- R2: While `boot_n` is 0, a strobe cycle at any address drives `rom_cs_n` low and keeps `ram_cs_n` high, one clock after the strobe is first sampled low.
- R3: `boot_n` rises on the clock edge that samples the strobe high at the end of the fourth cycle after reset, and stays high until the next reset. The fifth cycle at address 0 then selects RAM.
- R4: With boot inactive, byte addresses whose bits 23:16 equal the ROM page (0x50 by default, 0xFF with `ROM_AT_TOP`=1) select ROM. The page bounds 0x500000 and 0x50FFFE are included, and 0x510000 and 0x5F0000 are excluded.
- R5: With boot inactive, byte addresses below 0x400000 select RAM. Address 0x3FFFFE selects RAM and 0x400000 does not.
- R6: Page 0xFE selects serial, 0xFD selects video and 0xFB selects the microcontroller. At most one chip select is ever low, and an address matching no region drives none low.
- R7: On the clock after the strobe is sampled high, every chip select and enable is high.
- R8: On a read (`rw`=1) to ROM or RAM, the high-lane output enable (data 15:8) is low exactly when `uds_n` is low, and the low-lane enable (data 7:0) is low exactly when `lds_n` is low.
- R9: On a write (`rw`=0) to RAM, the high-lane write enable follows `uds_n` and the low-lane enable follows `lds_n`. No output enable is low on any write, and no write enable is low on any read.
- R10: For a mapped cycle, `dtack_n` goes low after the (`WAIT_CLKS`+1)-th clock edge that samples the strobe low (3 with defaults). It returns high on the first edge that samples the strobe high.
- R11: For an unmapped cycle, `dtack_n` goes low after the (`TIMEOUT_CLKS`+1)-th edge (9 with defaults). `unmapped` becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 23 | Word address, byte address bits 23:1 |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper byte lane strobe (data 15:8), active low |
| lds_n | input | 1 | Lower byte lane strobe (data 7:0), active low |
| rw | input | 1 | 1 = read, 0 = write |
| boot_n | output | 1 | Boot overlay active when low |
| rom_cs_n | output | 1 | ROM select |
| ram_cs_n | output | 1 | RAM select |
| ser_cs_n | output | 1 | Serial select |
| vid_cs_n | output | 1 | Video select |
| mcu_cs_n | output | 1 | Microcontroller select |
| rom_oe_hi_n | output | 1 | ROM high-lane output enable |
| rom_oe_lo_n | output | 1 | ROM low-lane output enable |
| ram_oe_hi_n | output | 1 | RAM high-lane output enable |
| ram_oe_lo_n | output | 1 | RAM low-lane output enable |
| ram_we_hi_n | output | 1 | RAM high-lane write enable |
| ram_we_lo_n | output | 1 | RAM low-lane write enable |
| dtack_n | output | 1 | Transfer acknowledge, active low |
| unmapped | output | 1 | Sticky flag recording an access to an unmapped address |

## Verification
The assertions assume that address, read/write and lane strobes are synchronous to `clk` and stay steady while the address strobe is low. They also assume the strobe is high while reset is applied. The stimulus honours this by changing these inputs only on the falling clock edge. New values are applied together with the strobe's falling edge, and the lane strobes are released together with the address strobe. Every cycle also leaves at least one idle clock before the next strobe, so the end-of-cycle edge that advances the boot count is always seen.

// File: rtl/bdg_pkg.sv
package bdg_pkg;

  typedef enum logic [2:0] {
    REG_NONE = 3'd0,
    REG_ROM  = 3'd1,
    REG_RAM  = 3'd2,
    REG_SER  = 3'd3,
    REG_VID  = 3'd4,
    REG_MCU  = 3'd5
  } region_t;

  localparam int NUM_CS = 5;

endpackage

// File: rtl/bdg_boot.sv
// Boot overlay: counts completed strobe cycles since reset and keeps
// boot_n low until BOOT_CYCLES of them have ended.
module bdg_boot #(
  parameter int BOOT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic as_n,
  output logic boot_n
);

  logic                   as_q;
  logic [BOOT_CYCLES-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      as_q <= 1'b1;
      seen <= '0;
    end else begin
      as_q <= as_n;
      if (!as_q && as_n)
        seen <= (seen << 1) | BOOT_CYCLES'(1);
    end
  end

  assign boot_n = seen[BOOT_CYCLES-1];

endmodule

// File: rtl/bdg_decode.sv
// Address map: combinational region lookup on the word address.
module bdg_decode
  import bdg_pkg::*;
#(
  parameter int          ADDR_W     = 24,
  parameter int          RAM_BYTES  = 4194304,
  parameter bit          ROM_AT_TOP = 1'b0,
  parameter logic [7:0]  ROM_PAGE_LO = 8'h50,
  parameter logic [7:0]  ROM_PAGE_HI = 8'hFF,
  parameter logic [7:0]  SER_PAGE   = 8'hFE,
  parameter logic [7:0]  VID_PAGE   = 8'hFD,
  parameter logic [7:0]  MCU_PAGE   = 8'hFB
) (
  input  logic [ADDR_W-1:1] addr,
  input  logic              boot_act,
  output region_t           region
);

  localparam int PAGE_W = ADDR_W - 16;
  localparam logic [ADDR_W-2:0] RAM_WORDS = (ADDR_W-1)'(RAM_BYTES / 2);

  logic [PAGE_W-1:0] page;
  logic              rom_hit;

  assign page = addr[ADDR_W-1:16];

  generate
    if (ROM_AT_TOP) begin : g_rom_top
      assign rom_hit = (page == PAGE_W'(ROM_PAGE_HI));
    end else begin : g_rom_low
      assign rom_hit = (page == PAGE_W'(ROM_PAGE_LO));
    end
  endgenerate

  always_comb begin
    if (boot_act)                       region = REG_ROM;
    else if (rom_hit)                   region = REG_ROM;
    else if (page == PAGE_W'(SER_PAGE)) region = REG_SER;
    else if (page == PAGE_W'(VID_PAGE)) region = REG_VID;
    else if (page == PAGE_W'(MCU_PAGE)) region = REG_MCU;
    else if (addr < RAM_WORDS)          region = REG_RAM;
    else                                region = REG_NONE;
  end

endmodule

// File: rtl/bdg_ack.sv
// Wait-state counter: acknowledges a mapped cycle after WAIT_CLKS,
// any cycle after TIMEOUT_CLKS, and records unmapped accesses.
module bdg_ack #(
  parameter int WAIT_CLKS    = 2,
  parameter int TIMEOUT_CLKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic as_n,
  input  logic mapped,
  output logic dtack_n,
  output logic unmapped
);

  localparam int CW = $clog2(TIMEOUT_CLKS + 1);
  localparam logic [CW-1:0] WAIT_V = CW'(WAIT_CLKS);
  localparam logic [CW-1:0] TOUT_V = CW'(TIMEOUT_CLKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      dtack_n  <= 1'b1;
      unmapped <= 1'b0;
    end else if (as_n) begin
      cnt     <= '0;
      dtack_n <= 1'b1;
    end else begin
      if (cnt != TOUT_V)
        cnt <= cnt + CW'(1);
      if ((mapped && cnt >= WAIT_V) || cnt == TOUT_V)
        dtack_n <= 1'b0;
      if (!mapped)
        unmapped <= 1'b1;
    end
  end

endmodule

// File: rtl/boot_decode_glue.sv
module boot_decode_glue
  import bdg_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int RAM_BYTES    = 4194304,
  parameter bit ROM_AT_TOP   = 1'b0,
  parameter int BOOT_CYCLES  = 4,
  parameter int WAIT_CLKS    = 2,
  parameter int TIMEOUT_CLKS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:1] addr_i,
  input  logic              as_n,
  input  logic              uds_n,
  input  logic              lds_n,
  input  logic              rw,
  output logic              boot_n,
  output logic              rom_cs_n,
  output logic              ram_cs_n,
  output logic              ser_cs_n,
  output logic              vid_cs_n,
  output logic              mcu_cs_n,
  output logic              rom_oe_hi_n,
  output logic              rom_oe_lo_n,
  output logic              ram_oe_hi_n,
  output logic              ram_oe_lo_n,
  output logic              ram_we_hi_n,
  output logic              ram_we_lo_n,
  output logic              dtack_n,
  output logic              unmapped
);

  localparam int LANES = 2;

  region_t           region;
  logic              sel;
  logic [NUM_CS-1:0] cs_q;
  logic [LANES-1:0]  stb;
  logic [LANES-1:0]  rom_oe_q, ram_oe_q, ram_we_q;

  bdg_boot #(.BOOT_CYCLES(BOOT_CYCLES)) u_boot (
    .clk(clk), .rst(rst), .as_n(as_n), .boot_n(boot_n)
  );

  bdg_decode #(
    .ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES), .ROM_AT_TOP(ROM_AT_TOP)
  ) u_decode (
    .addr(addr_i), .boot_act(!boot_n), .region(region)
  );

  bdg_ack #(.WAIT_CLKS(WAIT_CLKS), .TIMEOUT_CLKS(TIMEOUT_CLKS)) u_ack (
    .clk(clk), .rst(rst), .as_n(as_n), .mapped(region != REG_NONE),
    .dtack_n(dtack_n), .unmapped(unmapped)
  );

  assign sel = !as_n;
  assign stb = {!uds_n, !lds_n};

  // Chip selects: bit i corresponds to region code i+1.
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q <= '1;
    end else begin
      for (int i = 0; i < NUM_CS; i++)
        cs_q[i] <= !(sel && region == region_t'(i + 1));
    end
  end

  // Per-lane enables, index 1 = data 15:8, index 0 = data 7:0.
  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst) begin
          rom_oe_q[l] <= 1'b1;
          ram_oe_q[l] <= 1'b1;
          ram_we_q[l] <= 1'b1;
        end else begin
          rom_oe_q[l] <= !(sel && stb[l] && rw  && region == REG_ROM);
          ram_oe_q[l] <= !(sel && stb[l] && rw  && region == REG_RAM);
          ram_we_q[l] <= !(sel && stb[l] && !rw && region == REG_RAM);
        end
      end
    end
  endgenerate

  assign rom_cs_n    = cs_q[0];
  assign ram_cs_n    = cs_q[1];
  assign ser_cs_n    = cs_q[2];
  assign vid_cs_n    = cs_q[3];
  assign mcu_cs_n    = cs_q[4];
  assign rom_oe_hi_n = rom_oe_q[1];
  assign rom_oe_lo_n = rom_oe_q[0];
  assign ram_oe_hi_n = ram_oe_q[1];
  assign ram_oe_lo_n = ram_oe_q[0];
  assign ram_we_hi_n = ram_we_q[1];
  assign ram_we_lo_n = ram_we_q[0];

endmodule

// File: rtl/bdg_chk.sv
module bdg_chk (
  input logic clk,
  input logic rst,
  input logic as_n,
  input logic rw,
  input logic boot_n,
  input logic rom_cs_n,
  input logic ram_cs_n,
  input logic ser_cs_n,
  input logic vid_cs_n,
  input logic mcu_cs_n,
  input logic rom_oe_hi_n,
  input logic rom_oe_lo_n,
  input logic ram_oe_hi_n,
  input logic ram_oe_lo_n,
  input logic ram_we_hi_n,
  input logic ram_we_lo_n,
  input logic dtack_n,
  input logic unmapped
);

  logic [4:0] cs_all;
  assign cs_all = {rom_cs_n, ram_cs_n, ser_cs_n, vid_cs_n, mcu_cs_n};

  p_boot_rom_r2: assert property (@(posedge clk) disable iff (rst)
    (!boot_n && !as_n) |=> (!rom_cs_n && ram_cs_n));

  p_boot_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    boot_n |=> boot_n);

  p_one_select_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_all));

  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    as_n |=> (&cs_all && rom_oe_hi_n && rom_oe_lo_n && ram_oe_hi_n &&
              ram_oe_lo_n && ram_we_hi_n && ram_we_lo_n));

  p_read_no_we_r9: assert property (@(posedge clk) disable iff (rst)
    (!as_n && rw) |=> (ram_we_hi_n && ram_we_lo_n));

  p_write_no_oe_r9: assert property (@(posedge clk) disable iff (rst)
    (!as_n && !rw) |=> (rom_oe_hi_n && rom_oe_lo_n && ram_oe_hi_n && ram_oe_lo_n));

  p_release_r10: assert property (@(posedge clk) disable iff (rst)
    as_n |=> dtack_n);

  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    unmapped |=> unmapped);

endmodule

bind boot_decode_glue bdg_chk u_chk (
  .clk(clk), .rst(rst), .as_n(as_n), .rw(rw), .boot_n(boot_n),
  .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .ser_cs_n(ser_cs_n),
  .vid_cs_n(vid_cs_n), .mcu_cs_n(mcu_cs_n),
  .rom_oe_hi_n(rom_oe_hi_n), .rom_oe_lo_n(rom_oe_lo_n),
  .ram_oe_hi_n(ram_oe_hi_n), .ram_oe_lo_n(ram_oe_lo_n),
  .ram_we_hi_n(ram_we_hi_n), .ram_we_lo_n(ram_we_lo_n),
  .dtack_n(dtack_n), .unmapped(unmapped)
);

// File: tb/tb_boot_decode_glue.sv
module tb_boot_decode_glue;

  localparam int WAIT_CLKS    = 2;
  localparam int TIMEOUT_CLKS = 8;
  localparam int LAT_MAP      = WAIT_CLKS + 1;
  localparam int LAT_NONE     = TIMEOUT_CLKS + 1;

  // cs order {rom, ram, ser, vid, mcu}, active low
  localparam logic [4:0] CS_ROM  = 5'b01111;
  localparam logic [4:0] CS_RAM  = 5'b10111;
  localparam logic [4:0] CS_SER  = 5'b11011;
  localparam logic [4:0] CS_VID  = 5'b11101;
  localparam logic [4:0] CS_MCU  = 5'b11110;
  localparam logic [4:0] CS_NONE = 5'b11111;

  localparam int NV = 12;
  localparam logic [28:0] VEC [NV] = '{
    {24'h000000, CS_RAM},  // R5
    {24'h3FFFFE, CS_RAM},  // R5 upper bound
    {24'h400000, CS_NONE}, // R5 just past RAM
    {24'h500000, CS_ROM},  // R4
    {24'h50FFFE, CS_ROM},  // R4 page end
    {24'h510000, CS_NONE}, // R4 next page
    {24'h5F0000, CS_NONE}, // R4 partial decode excluded
    {24'hFE0010, CS_SER},  // R6
    {24'hFD0000, CS_VID},  // R6
    {24'hFB1234, CS_MCU},  // R6
    {24'hFF0000, CS_NONE}, // R6 alternate ROM page unused by default
    {24'hFC0000, CS_NONE}  // R6
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:1] addr_i = '0;
  logic        as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rw = 1'b1;
  logic        boot_n, rom_cs_n, ram_cs_n, ser_cs_n, vid_cs_n, mcu_cs_n;
  logic        rom_oe_hi_n, rom_oe_lo_n, ram_oe_hi_n, ram_oe_lo_n;
  logic        ram_we_hi_n, ram_we_lo_n, dtack_n, unmapped;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  boot_decode_glue #(.WAIT_CLKS(WAIT_CLKS), .TIMEOUT_CLKS(TIMEOUT_CLKS)) dut (
    .clk(clk), .rst(rst), .addr_i(addr_i), .as_n(as_n), .uds_n(uds_n),
    .lds_n(lds_n), .rw(rw), .boot_n(boot_n), .rom_cs_n(rom_cs_n),
    .ram_cs_n(ram_cs_n), .ser_cs_n(ser_cs_n), .vid_cs_n(vid_cs_n),
    .mcu_cs_n(mcu_cs_n), .rom_oe_hi_n(rom_oe_hi_n), .rom_oe_lo_n(rom_oe_lo_n),
    .ram_oe_hi_n(ram_oe_hi_n), .ram_oe_lo_n(ram_oe_lo_n),
    .ram_we_hi_n(ram_we_hi_n), .ram_we_lo_n(ram_we_lo_n),
    .dtack_n(dtack_n), .unmapped(unmapped)
  );

  function automatic logic [4:0] cs_vec();
    return {rom_cs_n, ram_cs_n, ser_cs_n, vid_cs_n, mcu_cs_n};
  endfunction

  // {rom_oe_hi, rom_oe_lo, ram_oe_hi, ram_oe_lo, ram_we_hi, ram_we_lo}
  function automatic logic [5:0] lane_vec();
    return {rom_oe_hi_n, rom_oe_lo_n, ram_oe_hi_n, ram_oe_lo_n, ram_we_hi_n, ram_we_lo_n};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // One strobe cycle; captures selects and lanes one edge after the strobe
  // falls, counts edges until acknowledge, then checks the idle state.
  task automatic run_cycle(input logic [23:0] a, input logic r, input logic u,
                           input logic l, output logic [4:0] cs,
                           output logic [5:0] ln, output int lat);
    @(negedge clk);
    addr_i = a[23:1]; rw = r; uds_n = u; lds_n = l; as_n = 1'b0;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (lat == 1) begin
        cs = cs_vec();
        ln = lane_vec();
      end
    end while (dtack_n && lat < 40);
    as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R7 selects idle after strobe high", {26'd0, cs_vec(), lane_vec() == 6'h3F}, {26'd0, CS_NONE, 1'b1});
    chk("R10 dtack released", dtack_n, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [4:0] cs;
    logic [5:0] ln;
    int         lat;
    logic [23:0] boot_addr [4];
    boot_addr[0] = 24'h000000; boot_addr[1] = 24'h000002;
    boot_addr[2] = 24'h400000; boot_addr[3] = 24'hFE0000;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 boot_n in reset", boot_n, 1'b0);
    chk("R1 selects in reset", cs_vec(), CS_NONE);
    chk("R1 lanes in reset", lane_vec(), 6'h3F);
    chk("R1 dtack/unmapped in reset", {dtack_n, unmapped}, 2'b10);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 state after release", {boot_n, cs_vec(), dtack_n, unmapped}, {1'b0, CS_NONE, 2'b10});

    // R2/R3: boot overlay for four cycles
    for (int i = 0; i < 4; i++) begin
      run_cycle(boot_addr[i], 1'b1, 1'b0, 1'b0, cs, ln, lat);
      chk("R2 boot cycle selects ROM", cs, CS_ROM);
      chk("R8 boot read ROM lanes", ln, 6'b001111);
      chk("R10 boot dtack latency", lat, LAT_MAP);
      chk("R3 boot_n after cycle", boot_n, (i == 3) ? 1'b1 : 1'b0);
    end
    run_cycle(24'h000000, 1'b1, 1'b0, 1'b0, cs, ln, lat);
    chk("R3 fifth cycle selects RAM", cs, CS_RAM);
    chk("R8 RAM read lanes", ln, 6'b110011);
    chk("R11 flag clear before unmapped", unmapped, 1'b0);

    // Table walk over the address map
    for (int v = 0; v < NV; v++) begin
      run_cycle(VEC[v][28:5], 1'b1, 1'b0, 1'b0, cs, ln, lat);
      chk($sformatf("R4/R5/R6 decode of %06h", VEC[v][28:5]), cs, VEC[v][4:0]);
      chk($sformatf("R10/R11 latency at %06h", VEC[v][28:5]), lat,
          (VEC[v][4:0] == CS_NONE) ? LAT_NONE : LAT_MAP);
    end
    chk("R11 unmapped flag set", unmapped, 1'b1);
    chk("R3 boot_n still high", boot_n, 1'b1);

    // R8/R9: all strobe and direction combinations on ROM and RAM
    for (int t = 0; t < 2; t++) begin
      for (int k = 0; k < 8; k++) begin
        logic r, u, l, is_rom;
        logic [5:0] exp;
        r = k[2]; u = k[1]; l = k[0];
        is_rom = (t == 0);
        exp[5] = !(is_rom && r && !u);
        exp[4] = !(is_rom && r && !l);
        exp[3] = !(!is_rom && r && !u);
        exp[2] = !(!is_rom && r && !l);
        exp[1] = !(!is_rom && !r && !u);
        exp[0] = !(!is_rom && !r && !l);
        run_cycle(is_rom ? 24'h500100 : 24'h000100, r, u, l, cs, ln, lat);
        chk($sformatf("R8/R9 lanes rom=%0d rw=%0d uds=%0d lds=%0d", is_rom, r, u, l), ln, exp);
        chk("R4/R5 select during lane test", cs, is_rom ? CS_ROM : CS_RAM);
      end
    end
    chk("R11 flag stays set", unmapped, 1'b1);

    // Second reset re-arms the overlay
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset rearms boot and clears flag", {boot_n, unmapped}, 2'b00);
    run_cycle(24'h400000, 1'b1, 1'b0, 1'b0, cs, ln, lat);
    chk("R2 boot overrides unmapped address", cs, CS_ROM);
    chk("R2 boot cycle acknowledged as mapped", lat, LAT_MAP);
    chk("R3 one cycle keeps boot active", boot_n, 1'b0);
    chk("R11 no flag during boot", unmapped, 1'b0);

    finish_run();
  end

endmodule